// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing engine of a small serial memory with 128 bytes. It runs on the system clock and oversamples the two open-drain bus lines through synchronizers. It recognises start and stop conditions and collects the device address byte. It acknowledges only when the address carries the fixed type code and the three strap pins, and only when the memory is not busy. A busy memory therefore stays silent, and a master can poll it for the end of an internal write.

After a write address, the engine takes the next byte as the word address and hands it to the address counter. It passes every later byte to the page buffer, and it requests a commit when a stop closes a write that carried data. After a read address, it fetches a byte from the address counter and shifts it out most significant bit first. It keeps sending bytes for as long as the master acknowledges them. A repeated start after the word address gives a random read, and no commit follows it.

Top module: `tws_slave_engine`

## Requirements
- R1: A start (SDA falling while SCL is high) begins address reception from any state and aborts the transfer in progress. A stop (SDA rising while SCL is high) returns the engine to idle. Bus activity before the first start gets no response.
- R2: Bit 7 of the first byte arrives first. Bits 7..4 of that byte must equal 1010, bits 3..1 must equal strap[2:0], and bit 0 is R/W (1 = read, 0 = write). On a match the engine drives `sda_pull` high for the whole of the ninth clock. On a mismatch it gives no acknowledge and ignores the bus until the next start or stop.
- R3: While `busy` is 1, the address byte is never acknowledged, whatever its value.
- R4: In a write, the byte after the address is the word address. It is acknowledged, and `wa_load` pulses for one cycle with `wa_value` equal to bits 6..0 of that byte. Bit 7 is ignored.
- R5: Every byte after the word address is acknowledged, and `wb_push` pulses for one cycle with `wb_data` equal to the byte.
- R6: A stop that ends a write in which at least one data byte was pushed gives exactly one `wr_commit` pulse. A stop after a write with no data byte gives none, and a start cancels a pending commit.
- R7: In a read, the engine pulses `rd_take` as it loads `rd_data`, then sends the byte most significant bit first, one bit per SCL clock. It releases SDA during the ninth clock.
- R8: When the master drives SDA low in the ninth clock of a read byte, the engine loads and sends the next byte. When the master leaves SDA high, the engine sends nothing more and pulses `rd_take` no more until the next start.
- R9: `sda_pull` (1 = pull SDA low, 0 = release) is only ever asserted while the synchronized SCL is low, and it is released after a stop.
- R10: A start issued after the word-address acknowledge, followed by a read address, returns the byte at the loaded word address. No `wb_push` and no `wr_commit` follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen on the wire |
| sda_in | input | 1 | Bus data line as seen on the wire (wired-AND level) |
| strap | input | 3 | Device select strap pins |
| busy | input | 1 | Internal write cycle in progress |
| rd_data | input | 8 | Byte at the current address counter position |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |
| wa_load | output | 1 | One-cycle pulse: load the address counter |
| wa_value | output | 7 | Word address to load |
| wb_push | output | 1 | One-cycle pulse: push a byte into the page buffer |
| wb_data | output | 8 | Byte to push |
| rd_take | output | 1 | One-cycle pulse: rd_data taken, advance the counter |
| wr_commit | output | 1 | One-cycle pulse: begin the internal write |

## Verification
The address comparator is tried with a table of first bytes. The table holds an exact match for read and for write, bytes with a wrong type nibble, bytes with a wrong strap field, and matches presented while busy, so each case shows which of the three fields blocks the acknowledge. Directed sequences then cover several patterns: clocking before any start, a word address with its top bit set, a two-byte write closed by a stop, a sequential read ended by a master no-acknowledge and followed by idle clocks, a random read through a dummy write, and a start that cuts a data byte short. Together they tell a pushed byte from a committed write, and a repeated start from a stop.

// File: rtl/tws_pkg.sv
package tws_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RX,
      S_ACK,
      S_TX,
      S_MACK,
      S_HOLD
   } tws_state_e;

   typedef enum logic [1:0] {
      K_DEV,
      K_WADR,
      K_WDAT
   } tws_kind_e;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
   parameter int  LINES   = 2,
   parameter int  STAGES  = 2,
   parameter bit  IDLE_LV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] d,
   output logic [LINES-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tws_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{IDLE_LV}};
         else        chain <= {chain[STAGES-2:0], d[g]};
      end
      assign q[g] = chain[STAGES-1];
   end

endmodule

// File: rtl/tws_cond.sv
module tws_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise = !scl_q &&  scl_s;
   assign scl_fall =  scl_q && !scl_s;
   assign start_ev =  scl_q &&  scl_s &&  sda_q && !sda_s;
   assign stop_ev  =  scl_q &&  scl_s && !sda_q &&  sda_s;

endmodule

// File: rtl/tws_fsm.sv
module tws_fsm
   import tws_pkg::*;
#(
   parameter int             DATA_W    = 8,
   parameter int             ADDR_W    = 7,
   parameter int             STRAP_W   = 3,
   parameter int             TYPE_W    = 4,
   parameter logic [TYPE_W-1:0] TYPE_CODE = 4'b1010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_lvl,
   input  logic               sda_lvl,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_ev,
   input  logic               stop_ev,
   input  logic [STRAP_W-1:0] strap,
   input  logic               busy,
   input  logic [DATA_W-1:0]  rd_data,
   output logic               sda_pull,
   output logic               wa_load,
   output logic [ADDR_W-1:0]  wa_value,
   output logic               wb_push,
   output logic [DATA_W-1:0]  wb_data,
   output logic               rd_take,
   output logic               wr_commit
);

   localparam int BIT_CW = $clog2(DATA_W + 1);
   localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(DATA_W);

   tws_state_e        st;
   tws_kind_e         kind;
   logic [DATA_W-1:0] sr;
   logic [BIT_CW-1:0] bitcnt;
   logic              rnw;
   logic              wrote;
   logic              mack;
   logic              dev_hit;

   assign dev_hit = (sr[DATA_W-1:1] == {TYPE_CODE, strap});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         kind      <= K_DEV;
         sr        <= '0;
         bitcnt    <= '0;
         rnw       <= 1'b0;
         wrote     <= 1'b0;
         mack      <= 1'b0;
         sda_pull  <= 1'b0;
         wa_load   <= 1'b0;
         wa_value  <= '0;
         wb_push   <= 1'b0;
         wb_data   <= '0;
         rd_take   <= 1'b0;
         wr_commit <= 1'b0;
      end else begin
         wa_load   <= 1'b0;
         wb_push   <= 1'b0;
         rd_take   <= 1'b0;
         wr_commit <= 1'b0;
         if (start_ev) begin
            st       <= S_RX;
            kind     <= K_DEV;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
            wrote    <= 1'b0;
         end else if (stop_ev) begin
            st        <= S_IDLE;
            sda_pull  <= 1'b0;
            wr_commit <= wrote;
            wrote     <= 1'b0;
         end else begin
            case (st)
               S_RX: begin
                  if (scl_rise) begin
                     sr     <= {sr[DATA_W-2:0], sda_lvl};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == LAST_BIT) begin
                     bitcnt <= '0;
                     case (kind)
                        K_DEV: begin
                           if (dev_hit && !busy) begin
                              st       <= S_ACK;
                              sda_pull <= 1'b1;
                              rnw      <= sr[0];
                           end else begin
                              st <= S_HOLD;
                           end
                        end
                        K_WADR: begin
                           st       <= S_ACK;
                           sda_pull <= 1'b1;
                           wa_load  <= 1'b1;
                           wa_value <= sr[ADDR_W-1:0];
                        end
                        default: begin
                           st       <= S_ACK;
                           sda_pull <= 1'b1;
                           wb_push  <= 1'b1;
                           wb_data  <= sr;
                           wrote    <= 1'b1;
                        end
                     endcase
                  end
               end
               S_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (kind == K_DEV && rnw) begin
                        st       <= S_TX;
                        sr       <= rd_data;
                        rd_take  <= 1'b1;
                        sda_pull <= ~rd_data[DATA_W-1];
                     end else begin
                        st       <= S_RX;
                        sda_pull <= 1'b0;
                        kind     <= (kind == K_DEV) ? K_WADR : K_WDAT;
                     end
                  end
               end
               S_TX: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bitcnt == LAST_BIT) begin
                        st       <= S_MACK;
                        sda_pull <= 1'b0;
                     end else begin
                        sr       <= {sr[DATA_W-2:0], 1'b0};
                        sda_pull <= ~sr[DATA_W-2];
                     end
                  end
               end
               S_MACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (mack) begin
                        st       <= S_TX;
                        sr       <= rd_data;
                        rd_take  <= 1'b1;
                        sda_pull <= ~rd_data[DATA_W-1];
                        bitcnt   <= '0;
                     end else begin
                        st <= S_HOLD;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R9
   pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl_lvl);

   // R1
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> !sda_pull);

   // R3
   busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_pull) && st == S_ACK && kind == K_DEV) |-> !$past(busy));

   // R6
   commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> $past(stop_ev));

   // R7
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_TX && $past(st == S_TX) && !$past(scl_fall) && !$past(start_ev))
         |-> $stable(sda_pull));

   // R5
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wa_load, wb_push, rd_take, wr_commit}));

endmodule

// File: rtl/tws_slave_engine.sv
module tws_slave_engine #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 7,
   parameter int STRAP_W     = 3,
   parameter int TYPE_W      = 4,
   parameter logic [TYPE_W-1:0] TYPE_CODE = 4'b1010,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_in,
   input  logic               sda_in,
   input  logic [STRAP_W-1:0] strap,
   input  logic               busy,
   input  logic [DATA_W-1:0]  rd_data,
   output logic               sda_pull,
   output logic               wa_load,
   output logic [ADDR_W-1:0]  wa_value,
   output logic               wb_push,
   output logic [DATA_W-1:0]  wb_data,
   output logic               rd_take,
   output logic               wr_commit
);

   if (TYPE_W + STRAP_W + 1 != DATA_W) begin : g_bad_addr_fmt
      $error("tws_slave_engine: type, strap and R/W must fill one byte");
   end
   if (ADDR_W >= DATA_W) begin : g_bad_addr_w
      $error("tws_slave_engine: word address must fit below the byte MSB");
   end

   logic [1:0] raw_lines, sync_lines;
   logic       scl_rise, scl_fall, start_ev, stop_ev;

   assign raw_lines = {scl_in, sda_in};

   tws_sync #(
      .LINES   (2),
      .STAGES  (SYNC_STAGES),
      .IDLE_LV (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_lines),
      .q     (sync_lines)
   );

   tws_cond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (sync_lines[1]),
      .sda_s    (sync_lines[0]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   tws_fsm #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .STRAP_W   (STRAP_W),
      .TYPE_W    (TYPE_W),
      .TYPE_CODE (TYPE_CODE)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_lvl   (sync_lines[1]),
      .sda_lvl   (sync_lines[0]),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_ev  (start_ev),
      .stop_ev   (stop_ev),
      .strap     (strap),
      .busy      (busy),
      .rd_data   (rd_data),
      .sda_pull  (sda_pull),
      .wa_load   (wa_load),
      .wa_value  (wa_value),
      .wb_push   (wb_push),
      .wb_data   (wb_data),
      .rd_take   (rd_take),
      .wr_commit (wr_commit)
   );

endmodule

// File: tb/tb_tws_slave_engine.sv
module tb_tws_slave_engine;

   localparam int H = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       busy = 1'b0;
   logic [2:0] strap = 3'b101;
   logic [6:0] ptr = '0;
   logic [7:0] rd_data;
   logic       sda_line;
   logic       sda_pull, wa_load, wb_push, rd_take, wr_commit;
   logic [6:0] wa_value;
   logic [7:0] wb_data;

   int n_chk = 0, n_fail = 0;
   int n_wa = 0, n_wb = 0, n_rd = 0, n_cm = 0;
   logic [6:0] last_wa = '0;
   logic [7:0] last_wb = '0;

   always #4 clk = ~clk;

   function automatic logic [7:0] pat(input logic [6:0] a);
      return ({1'b0, a} * 8'd37) ^ 8'h5A;
   endfunction

   assign rd_data  = pat(ptr);
   assign sda_line = m_sda & ~sda_pull;

   tws_slave_engine dut (
      .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
      .strap(strap), .busy(busy), .rd_data(rd_data), .sda_pull(sda_pull),
      .wa_load(wa_load), .wa_value(wa_value), .wb_push(wb_push),
      .wb_data(wb_data), .rd_take(rd_take), .wr_commit(wr_commit)
   );

   always @(posedge clk) begin
      if (wa_load)   begin n_wa++; last_wa = wa_value; ptr <= wa_value; end
      if (wb_push)   begin n_wb++; last_wb = wb_data; end
      if (rd_take)   begin n_rd++; ptr <= ptr + 7'd1; end
      if (wr_commit) n_cm++;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      m_sda = 1'b1; tick(H);
      m_scl = 1'b1; tick(H);
      m_sda = 1'b0; tick(H);
      m_scl = 1'b0; tick(H);
   endtask

   task automatic bus_stop;
      m_sda = 1'b0; tick(H);
      m_scl = 1'b1; tick(H);
      m_sda = 1'b1; tick(H);
   endtask

   task automatic put_bit(input logic b);
      m_sda = b;    tick(H);
      m_scl = 1'b1; tick(H);
      m_scl = 1'b0; tick(4);
   endtask

   task automatic get_bit(output logic b);
      m_sda = 1'b1; tick(H);
      m_scl = 1'b1; tick(H/2);
      b = sda_line; tick(H/2);
      m_scl = 1'b0; tick(4);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(~give_ack);
   endtask

   // {first byte, busy, expected ack}
   localparam logic [9:0] VEC [0:7] = '{
      {8'hAA, 1'b0, 1'b1},
      {8'hAB, 1'b0, 1'b1},
      {8'hA8, 1'b0, 1'b0},
      {8'hBA, 1'b0, 1'b0},
      {8'hAE, 1'b0, 1'b0},
      {8'hEB, 1'b0, 1'b0},
      {8'hAA, 1'b1, 1'b0},
      {8'hAB, 1'b1, 1'b0}
   };

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic ack, b, all_high;
      logic [7:0] v;
      int c0, r0;
      tick(5);
      rst_n = 1'b1;
      tick(5);
      check("R9 reset pull", sda_pull, 0);
      check("R1 reset pulses", n_wa + n_wb + n_rd + n_cm, 0);

      // R1: address clocked without any start gets no acknowledge
      send_byte(8'hAA, ack);
      check("R1 no start no ack", ack, 0);
      check("R1 no start no load", n_wa, 0);

      // R2 R3: address table
      for (int i = 0; i < 8; i++) begin
         busy = VEC[i][1];
         bus_start;
         send_byte(VEC[i][9:2], ack);
         check("R2 R3 address ack", ack, VEC[i][0]);
         if (ack && VEC[i][2]) recv_byte(1'b0, v);
         if (!ack) begin
            send_byte(8'hAA, ack);
            check("R2 ignored until start", ack, 0);
         end
         bus_stop;
         busy = 1'b0;
      end

      // R4 R5 R6: two-byte write
      c0 = n_cm;
      bus_start;
      send_byte(8'hAA, ack);
      send_byte(8'hC5, ack);
      check("R4 word address ack", ack, 1);
      check("R4 word address MSB ignored", last_wa, 7'h45);
      send_byte(8'h3C, ack);
      check("R5 data ack", ack, 1);
      check("R5 data pushed", last_wb, 8'h3C);
      send_byte(8'h81, ack);
      check("R5 second data pushed", last_wb, 8'h81);
      check("R6 no commit before stop", n_cm, c0);
      bus_stop;
      check("R6 one commit on stop", n_cm, c0 + 1);

      // R7 R8: sequential current-address read
      r0 = n_rd;
      bus_start;
      send_byte(8'hAB, ack);
      check("R7 read address ack", ack, 1);
      recv_byte(1'b1, v);
      check("R7 first byte", v, pat(7'h45));
      recv_byte(1'b0, v);
      check("R8 next byte after ack", v, pat(7'h46));
      check("R8 two loads", n_rd, r0 + 2);
      all_high = 1'b1;
      for (int i = 0; i < 9; i++) begin
         get_bit(b);
         all_high = all_high & b;
      end
      check("R8 released after nack", all_high, 1);
      check("R8 no load after nack", n_rd, r0 + 2);
      bus_stop;
      check("R9 released after stop", sda_pull, 0);

      // R10: random read through dummy write
      c0 = n_cm;
      r0 = n_wb;
      bus_start;
      send_byte(8'hAA, ack);
      send_byte(8'h10, ack);
      bus_start;
      send_byte(8'hAB, ack);
      check("R10 read address ack", ack, 1);
      recv_byte(1'b0, v);
      check("R10 random byte", v, pat(7'h10));
      bus_stop;
      check("R10 no push", n_wb, r0);
      check("R6 R10 no commit", n_cm, c0);

      // R1: start cuts a data byte short
      bus_start;
      send_byte(8'hAA, ack);
      send_byte(8'h20, ack);
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
      bus_start;
      send_byte(8'hAB, ack);
      check("R1 restart ack", ack, 1);
      recv_byte(1'b0, v);
      check("R1 restart read", v, pat(7'h20));
      bus_stop;
      check("R1 aborted byte not pushed", n_wb, r0);
      check("R6 aborted write no commit", n_cm, c0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule